// File: doc/BRIEF.md
# PCM Frame Timing and Serializer

This block runs a two-channel serial audio port. It counts bit clocks through a programmable frame, produces the frame-sync signal, shifts transmit samples out MSB first, and assembles received bits into parallel samples. Each channel in each direction has its own enable, start position and width. One engine therefore covers I2S, left-justified, right-justified and both short-pulse DSP framings. The caller only has to choose positions, the frame-sync length and the polarities.

The block can generate the bit clock itself from the system clock, or follow an external one. It can also generate frame sync or follow an external one. External bit clock, frame sync and serial input are each synchronized with two flops and then handled in the system clock domain. Receive and transmit share one frame length. Their channel placement is configured separately.

Top module: `pcm_frame_engine`

## Requirements
- R1: The frame counter runs over bit indices 0 to `cfg_frame_len_m1`, so a frame is `cfg_frame_len_m1`+1 bit clocks long (up to 1024). After reset, `sdo` and `rx_vld` are low. When the block drives the bit clock, `bclk_o` is also low after reset. The first drive edge after reset begins bit 0.
- R2: When the block drives frame sync, its active level covers bit indices below `cfg_fs_len`. `fs_o` is high while active, or low while active when `cfg_fs_inv` is 1, in which case the frame starts on the falling edge. Before the first drive edge, `fs_o` sits at the inactive level.
- R3: The channel width is 8 + `wid` + 16·`wex`, where `wid` is the 4-bit width field and `wex` is the extension bit. Widths above 32 are limited to 32.
- R4: A transmit channel starts its MSB at bit index `pos` and sends `width` bits, MSB first. The sample is right-aligned in its 32-bit port (MSB at bit width-1) and is captured when its window starts.
- R5: Bit indices outside every enabled transmit window drive `sdo` low. Channel 0 wins if two windows overlap. A disabled receive channel never strobes `rx_vld`.
- R6: A receive channel collects `width` bits MSB first, starting at index `pos`. It then presents them on its `rx_smp` port right-aligned and zero-extended, with a one-cycle `rx_vld` pulse (bit 0 for channel 0, bit 1 for channel 1).
- R7: With `cfg_bclk_inv` = 0, `sdo` and `fs_o` change only on falling bit-clock edges and `sdi` is sampled on rising edges. With `cfg_bclk_inv` = 1 the two edges swap roles.
- R8: When the block drives the bit clock, `bclk_o` toggles every `BCLK_HALF` system clocks. `bclk_o` is held low when `cfg_bclk_follow` = 1. `fs_o` is held low when `cfg_fs_follow` = 1.
- R9: In follower mode, `bclk_i`, `fs_i` and `sdi` pass through two-flop synchronizers. The bit during which `fs_i` first shows its active level (after `cfg_fs_inv`) becomes bit 0. From the next bit on, transmit and receive follow that alignment.
- R10: Receive and transmit use independent enables, positions and widths against the one shared frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bclk_follow | input | 1 | 1: follow `bclk_i`; 0: generate the bit clock |
| cfg_fs_follow | input | 1 | 1: follow `fs_i`; 0: generate frame sync |
| cfg_bclk_inv | input | 1 | 0: sample on rising, drive on falling; 1: swapped |
| cfg_fs_inv | input | 1 | 1: frame sync is active low (frame starts on falling edge) |
| cfg_frame_len_m1 | input | 10 | Frame length minus one |
| cfg_fs_len | input | 10 | Frame-sync active length in bit clocks |
| cfg_rx_en | input | 2 | Receive channel enables |
| cfg_rx_pos | input | 2x10 | Receive channel MSB bit index |
| cfg_rx_wid | input | 2x4 | Receive width field |
| cfg_rx_wex | input | 2 | Receive width extension (+16) |
| cfg_tx_en | input | 2 | Transmit channel enables |
| cfg_tx_pos | input | 2x10 | Transmit channel MSB bit index |
| cfg_tx_wid | input | 2x4 | Transmit width field |
| cfg_tx_wex | input | 2 | Transmit width extension (+16) |
| bclk_i | input | 1 | External bit clock |
| fs_i | input | 1 | External frame sync |
| sdi | input | 1 | Serial data in |
| tx_smp0 | input | 32 | Channel 0 transmit sample |
| tx_smp1 | input | 32 | Channel 1 transmit sample |
| bclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Generated frame sync |
| sdo | output | 1 | Serial data out |
| rx_smp0 | output | 32 | Channel 0 received sample |
| rx_smp1 | output | 32 | Channel 1 received sample |
| rx_vld | output | 2 | Per-channel received-sample strobe |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:
- A channel whose MSB sits at index 0, as in DSP-B. An off-by-one counter would lose that bit or shift the whole word by one.
- A width field of 15 with the extension set. Without the limit to 32, bits from beyond the sample would be sent.
- A maximal 1024-bit frame. A counter that is too narrow would wrap early.
- Inverted clock and frame-sync polarity. A design using the wrong edge would move data by half a bit, or start frames on the wrong transition.
- Follower mode, where the bench supplies both clocks. A design that aligned to the frame-sync edge incorrectly would produce receive samples and transmit bits that are rotated by one position.

// File: rtl/pcm_frame_engine.sv
module pcm_frame_engine #(
  parameter int CNT_W     = 10,
  parameter int SMP_W     = 32,
  parameter int BCLK_HALF = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_bclk_follow,
  input  logic                      cfg_fs_follow,
  input  logic                      cfg_bclk_inv,
  input  logic                      cfg_fs_inv,
  input  logic [CNT_W-1:0]          cfg_frame_len_m1,
  input  logic [CNT_W-1:0]          cfg_fs_len,
  input  logic [1:0]                cfg_rx_en,
  input  logic [1:0][CNT_W-1:0]     cfg_rx_pos,
  input  logic [1:0][3:0]           cfg_rx_wid,
  input  logic [1:0]                cfg_rx_wex,
  input  logic [1:0]                cfg_tx_en,
  input  logic [1:0][CNT_W-1:0]     cfg_tx_pos,
  input  logic [1:0][3:0]           cfg_tx_wid,
  input  logic [1:0]                cfg_tx_wex,
  input  logic                      bclk_i,
  input  logic                      fs_i,
  input  logic                      sdi,
  input  logic [SMP_W-1:0]          tx_smp0,
  input  logic [SMP_W-1:0]          tx_smp1,
  output logic                      bclk_o,
  output logic                      fs_o,
  output logic                      sdo,
  output logic [SMP_W-1:0]          rx_smp0,
  output logic [SMP_W-1:0]          rx_smp1,
  output logic [1:0]                rx_vld
);

  localparam int CW = CNT_W + 1;
  localparam int IW = $clog2(SMP_W);
  localparam int DW = $clog2(BCLK_HALF + 1);

  function automatic logic [CW-1:0] chan_w(input logic [3:0] w, input logic e);
    logic [CW-1:0] v;
    v = CW'(8) + CW'(w) + (e ? CW'(16) : CW'(0));
    return (v > CW'(SMP_W)) ? CW'(SMP_W) : v;
  endfunction

  logic [2:0] bsy;
  logic [1:0] fsy, dsy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bsy <= '0; fsy <= '0; dsy <= '0;
    end else begin
      bsy <= {bsy[1:0], bclk_i};
      fsy <= {fsy[0], fs_i};
      dsy <= {dsy[0], sdi};
    end

  logic sdi_s, fs_lvl;
  assign sdi_s  = dsy[1];
  assign fs_lvl = fsy[1] ^ cfg_fs_inv;

  logic [DW-1:0] div;
  logic bclk_int, tick;
  assign tick = (div == DW'(BCLK_HALF - 1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div <= '0; bclk_int <= 1'b0;
    end else if (tick) begin
      div <= '0; bclk_int <= ~bclk_int;
    end else begin
      div <= div + 1'b1;
    end

  logic rise, fall, drv_e, smp_e;
  assign rise  = cfg_bclk_follow ? (bsy[1] & ~bsy[2]) : (tick & ~bclk_int);
  assign fall  = cfg_bclk_follow ? (~bsy[1] & bsy[2]) : (tick & bclk_int);
  assign drv_e = cfg_bclk_inv ? rise : fall;
  assign smp_e = cfg_bclk_inv ? fall : rise;

  logic [CNT_W-1:0] cnt, nc, nxt;
  logic started, fs_cur, fs_old, fs_start;
  assign fs_start = fs_cur & ~fs_old;
  assign nc  = !started ? '0 : (cnt == cfg_frame_len_m1) ? '0 : cnt + 1'b1;
  assign nxt = (cfg_fs_follow && fs_start) ? CNT_W'(1) : nc;

  assign bclk_o = ~cfg_bclk_follow & bclk_int;
  assign fs_o   = ~cfg_fs_follow & ((started & (cnt < cfg_fs_len)) ^ cfg_fs_inv);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [SMP_W-1:0] tsrc, thold, rsh, rshv, rsmp;
    logic [CW-1:0]    tw, toff, rw, roff;
    logic [IW-1:0]    tidx;
    logic             tin, tbit, rin, vld;

    assign tsrc = (c == 0) ? tx_smp0 : tx_smp1;
    assign tw   = chan_w(cfg_tx_wid[c], cfg_tx_wex[c]);
    assign toff = {1'b0, nxt} - {1'b0, cfg_tx_pos[c]};
    assign tin  = cfg_tx_en[c] && (nxt >= cfg_tx_pos[c]) && (toff < tw);
    assign tidx = IW'(tw - toff - CW'(1));
    assign tbit = (toff == '0) ? tsrc[tidx] : thold[tidx];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) thold <= '0;
      else if (drv_e && tin && toff == '0) thold <= tsrc;

    assign rw   = chan_w(cfg_rx_wid[c], cfg_rx_wex[c]);
    assign roff = {1'b0, cnt} - {1'b0, cfg_rx_pos[c]};
    assign rin  = started && cfg_rx_en[c] && (cnt >= cfg_rx_pos[c]) && (roff < rw);
    assign rshv = (roff == '0) ? {{(SMP_W-1){1'b0}}, sdi_s} : {rsh[SMP_W-2:0], sdi_s};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        rsh <= '0; rsmp <= '0; vld <= 1'b0;
      end else begin
        vld <= 1'b0;
        if (smp_e && rin) begin
          rsh <= rshv;
          if (roff == rw - CW'(1)) begin
            rsmp <= rshv;
            vld  <= 1'b1;
          end
        end
      end
  end

  assign rx_smp0 = g_ch[0].rsmp;
  assign rx_smp1 = g_ch[1].rsmp;
  assign rx_vld  = {g_ch[1].vld, g_ch[0].vld};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; started <= 1'b0; fs_cur <= 1'b0; fs_old <= 1'b0; sdo <= 1'b0;
    end else begin
      if (smp_e) begin
        fs_cur <= fs_lvl;
        fs_old <= fs_cur;
      end
      if (drv_e) begin
        started <= 1'b1;
        cnt     <= nxt;
        sdo     <= g_ch[0].tin ? g_ch[0].tbit : (g_ch[1].tin ? g_ch[1].tbit : 1'b0);
      end
    end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_e |=> $stable(cnt)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_e && started && !cfg_fs_follow && cnt == cfg_frame_len_m1) |=> cnt == '0); // R1
  AST_SDO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_e |=> $stable(sdo)); // R7
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld != 2'b00) |=> (rx_vld == 2'b00)); // R6
  AST_BCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bclk_follow && bclk_o != $past(bclk_o)) |=> $stable(bclk_o)); // R8

endmodule

// File: tb/pcm_frame_engine_test.sv
module pcm_frame_engine_test;
  localparam int HALF = 4;
  localparam int EXT_H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_bclk_follow, cfg_fs_follow, cfg_bclk_inv, cfg_fs_inv;
  logic [9:0] cfg_frame_len_m1, cfg_fs_len;
  logic [1:0] cfg_rx_en, cfg_tx_en, cfg_rx_wex, cfg_tx_wex;
  logic [1:0][9:0] cfg_rx_pos, cfg_tx_pos;
  logic [1:0][3:0] cfg_rx_wid, cfg_tx_wid;
  logic bclk_i = 1'b0, fs_i = 1'b0, sdi = 1'b0;
  logic [31:0] tx_smp0, tx_smp1, rx_smp0, rx_smp1;
  logic bclk_o, fs_o, sdo;
  logic [1:0] rx_vld;

  pcm_frame_engine uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_bclk_follow(cfg_bclk_follow), .cfg_fs_follow(cfg_fs_follow),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_fs_inv(cfg_fs_inv),
    .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_fs_len(cfg_fs_len),
    .cfg_rx_en(cfg_rx_en), .cfg_rx_pos(cfg_rx_pos), .cfg_rx_wid(cfg_rx_wid), .cfg_rx_wex(cfg_rx_wex),
    .cfg_tx_en(cfg_tx_en), .cfg_tx_pos(cfg_tx_pos), .cfg_tx_wid(cfg_tx_wid), .cfg_tx_wex(cfg_tx_wex),
    .bclk_i(bclk_i), .fs_i(fs_i), .sdi(sdi), .tx_smp0(tx_smp0), .tx_smp1(tx_smp1),
    .bclk_o(bclk_o), .fs_o(fs_o), .sdo(sdo), .rx_smp0(rx_smp0), .rx_smp1(rx_smp1), .rx_vld(rx_vld)
  );

  int checks = 0, fails = 0;
  int L, fsl;
  bit binv, finv;
  int pos[2][2], wid[2][2];
  bit en[2][2], wex[2][2];
  logic [31:0] val[2][2];
  bit rx_chk = 1'b0;
  int vcnt[2];

  function automatic int bw(int w, bit e);
    int v = 8 + w + (e ? 16 : 0);
    return (v > 32) ? 32 : v;
  endfunction

  function automatic logic [31:0] wmask(int w);
    return (w >= 32) ? 32'hffff_ffff : ((32'h1 << w) - 32'h1);
  endfunction

  // d = 0 transmit, d = 1 receive
  function automatic logic exp_bit(int d, int k);
    for (int c = 0; c < 2; c++) begin
      int w = bw(wid[d][c], wex[d][c]);
      if (en[d][c] && k >= pos[d][c] && k < pos[d][c] + w)
        return val[d][c][w - 1 - (k - pos[d][c])];
    end
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(bit follow);
    cfg_bclk_follow = follow; cfg_fs_follow = follow;
    cfg_bclk_inv = binv; cfg_fs_inv = finv;
    cfg_frame_len_m1 = 10'(L - 1); cfg_fs_len = 10'(fsl);
    for (int c = 0; c < 2; c++) begin
      cfg_tx_en[c] = en[0][c]; cfg_tx_pos[c] = 10'(pos[0][c]);
      cfg_tx_wid[c] = 4'(wid[0][c]); cfg_tx_wex[c] = wex[0][c];
      cfg_rx_en[c] = en[1][c]; cfg_rx_pos[c] = 10'(pos[1][c]);
      cfg_rx_wid[c] = 4'(wid[1][c]); cfg_rx_wex[c] = wex[1][c];
    end
    tx_smp0 = val[0][0]; tx_smp1 = val[0][1];
  endtask

  task automatic tick();
    @(negedge clk);
    if (rx_chk)
      for (int c = 0; c < 2; c++)
        if (rx_vld[c]) begin
          logic [31:0] got = (c == 0) ? rx_smp0 : rx_smp1;
          logic [31:0] exp = val[1][c] & wmask(bw(wid[1][c], wex[1][c]));
          vcnt[c]++;
          chk(en[1][c], "R5 disabled rx channel strobed", 32'(c), 32'hffff);
          chk(got == exp, "R6 R3 R10 rx sample", got, exp);
        end
  endtask

  task automatic do_reset(bit follow);
    rst_n = 1'b0;
    apply(follow);
    sdi = 1'b0;
    bclk_i = ~binv;
    fs_i = finv;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0 && rx_vld == 2'b00, "R1 reset idle sdo/rx_vld", {30'b0, sdo, |rx_vld}, 0);
    if (!follow) begin
      chk(bclk_o == 1'b0, "R1 reset bclk_o low", 32'(bclk_o), 0);
      chk(fs_o == finv, "R2 reset fs inactive", 32'(fs_o), 32'(finv));
    end
    rst_n = 1'b1;
    vcnt[0] = 0; vcnt[1] = 0;
  endtask

  task automatic end_counts();
    for (int c = 0; c < 2; c++)
      if (en[1][c]) chk(vcnt[c] >= 2, "R6 rx strobes per run", vcnt[c], 2);
      else          chk(vcnt[c] == 0, "R5 R10 disabled rx strobes", vcnt[c], 0);
    rx_chk = 1'b0;
  endtask

  task automatic run_prov();
    logic last, last_sdo;
    int hc, nd, k;
    bit seen;
    do_reset(1'b0);
    rx_chk = 1'b1;
    last = bclk_o; last_sdo = sdo; hc = 0; nd = 0; k = -1; seen = 0;
    while (nd < 3 * L) begin
      tick();
      hc++;
      if (bclk_o != last) begin
        if (seen) chk(hc == HALF, "R8 bclk half period", hc, HALF);
        seen = 1; hc = 0; last = bclk_o;
        if (bclk_o == binv) begin
          k = (k + 1) % L; nd++;
          chk(sdo == exp_bit(0, k), "R4 R5 R3 sdo bit", {k[30:0], sdo}, {k[30:0], exp_bit(0, k)});
          chk(fs_o == ((k < fsl) ^ finv), "R2 R1 fs level", {k[30:0], fs_o}, {k[30:0], 1'((k < fsl) ^ finv)});
          sdi = exp_bit(1, k);
          last_sdo = sdo;
        end else begin
          chk(sdo == last_sdo, "R7 sdo moved on sample edge", 32'(sdo), 32'(last_sdo));
        end
      end
    end
    repeat (2 * HALF + 2) tick();
    end_counts();
  endtask

  task automatic run_follow();
    int P = 5;
    do_reset(1'b1);
    for (int j = 0; j < P + 3 * L; j++) begin
      int idx = j - P;
      int fi = (idx >= 0) ? idx % L : 0;
      bclk_i = binv;
      fs_i = ((idx >= 0 && fi < fsl) ? 1'b1 : 1'b0) ^ finv;
      sdi = (idx >= 0) ? exp_bit(1, fi) : 1'b0;
      if (j == P + 1) rx_chk = 1'b1;
      repeat (EXT_H) tick();
      chk(bclk_o == 1'b0 && fs_o == 1'b0, "R8 outputs held low when following", {bclk_o, fs_o}, 0);
      bclk_i = ~binv;
      if (idx >= 1)
        chk(sdo == exp_bit(0, fi), "R9 follower sdo bit", {fi[30:0], sdo}, {fi[30:0], exp_bit(0, fi)});
      repeat (EXT_H) tick();
    end
    bclk_i = binv;
    repeat (3 * EXT_H) tick();
    end_counts();
  endtask

  task automatic rand_cfg(bit follow);
    int slot = (follow ? 33 : 32) + $urandom_range(0, 7);
    L = 2 * slot;
    fsl = $urandom_range(1, L - 1);
    binv = 1'($urandom_range(0, 1));
    finv = 1'($urandom_range(0, 1));
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 2; c++) begin
        int w, lo;
        wid[d][c] = $urandom_range(0, 15);
        wex[d][c] = 1'($urandom_range(0, 1));
        w = bw(wid[d][c], wex[d][c]);
        lo = (follow && c == 0) ? 1 : 0;
        pos[d][c] = c * slot + $urandom_range(lo, slot - w);
        en[d][c] = ($urandom_range(0, 3) != 0);
        val[d][c] = $urandom;
      end
  endtask

  task automatic dir_cfg(int fl, int fs, bit bi, bit fi, int p0, int p1, int wd, bit wx, bit e0, bit e1);
    L = fl; fsl = fs; binv = bi; finv = fi;
    for (int d = 0; d < 2; d++) begin
      pos[d][0] = p0; pos[d][1] = p1;
      for (int c = 0; c < 2; c++) begin
        wid[d][c] = wd; wex[d][c] = wx; val[d][c] = $urandom;
      end
      en[d][0] = e0; en[d][1] = e1;
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd5127);
    // R4 I2S style: delay one bit, 24-bit data, 50% frame sync, frame starts on falling edge
    dir_cfg(64, 32, 0, 1, 1, 33, 0, 1, 1, 1);   run_prov();
    // R4 DSP-B style: MSB at index 0, one-bit sync pulse, 16-bit
    dir_cfg(32, 1, 0, 0, 0, 16, 8, 0, 1, 1);     run_prov();
    // R4 right-justified: 20-bit data late by 12 in 32-bit slots, inverted bit clock (R7)
    dir_cfg(64, 32, 1, 0, 12, 44, 12, 0, 1, 1);  run_prov();
    // R3 width cap: 8+15+16 limited to 32
    dir_cfg(64, 32, 0, 0, 0, 32, 15, 1, 1, 1);   run_prov();
    // R5 both channels off: sdo stays low
    dir_cfg(48, 24, 1, 1, 2, 26, 4, 0, 0, 0);    run_prov();
    // R10 tx channel 1 off while rx channel 1 on
    dir_cfg(64, 32, 0, 0, 1, 33, 8, 0, 1, 1);
    en[0][1] = 1'b0;                              run_prov();
    // R1 maximum frame of 1024 bits
    dir_cfg(1024, 512, 0, 1, 1, 513, 0, 1, 1, 1); run_prov();
    for (int i = 0; i < 10; i++) begin rand_cfg(1'b0); run_prov(); end
    // R9 follower, directed then random
    dir_cfg(64, 32, 0, 1, 1, 33, 0, 1, 1, 1);    run_follow();
    for (int i = 0; i < 4; i++) begin rand_cfg(1'b1); run_follow(); end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=190000 expected=<190000");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule